// File: doc/BRIEF.md
# Erase Suspend and Resume Sequencer

This block runs a long, multi-phase erase on a modelled nonvolatile array under software control. Software writes a three-bit control word holding an erase-select bit, a high-voltage-enable bit and a suspend bit. A rising high-voltage-enable with erase-select set starts the erase. From then on an internal phase counter advances one step per clock until the last phase, and then the block raises a done flag together with a pass flag.

Software can suspend the erase at any time to read the array. The reads are serviced while erase-select and high-voltage-enable stay set. When the suspend bit is cleared, the erase resumes from the nearest checkpoint at or below the phase where it stopped. This means a suspended erase takes longer overall.

Suspends that come too soon after the previous resume (or after the start) count as violations. When enough violations pile up, the erase ends at once with the pass flag low.

Top module: `erase_seq_top`

## Requirements
- R1: A control write with erase-select=1, high-voltage=1 and suspend=0, made while the stored high-voltage bit is 0 and the stored suspend bit is 0, starts an erase. After that write's clock edge the phase is 0 and done=0.
- R2: While an erase is running (erase-select=1, high-voltage=1, suspend=0, done=0), the phase rises by one each clock. On the clock where the phase is PHASES-1, done becomes 1 with good=1, and the phase holds. An erase from phase 0 sets done on the PHASES-th clock after the start edge.
- R3: A write with suspend=1 during a running erase still advances the phase on its own edge. After that edge the phase is frozen and suspAck (stored suspend AND stored erase-select) reads 1.
- R4: A write with suspend=0 while the stored suspend bit is 1 and the stored high-voltage bit is 1 resumes the erase. On that edge the phase becomes the largest multiple of 2**CKPT_BITS that is at or below the phase held at suspension.
- R5: A write with suspend=0 while the stored high-voltage bit is 0 leaves the stored suspend bit at 1. suspAck stays 1 and the phase does not move.
- R6: A read request (rdReq=1) in a cycle with no running erase gives rdAck=1 and rdErr=0 in the next cycle, and changes no erase state. The same request during a running erase gives rdErr=1 and rdAck=0.
- R7: A suspend whose edge comes fewer than MIN_GAP+1 edges after the last start or resume edge counts a violation. A suspend exactly MIN_GAP+1 edges after does not.
- R8: On the edge of the VIOL_LIMIT-th violation, done becomes 1 and good becomes 0, and the erase stops.
- R9: A suspend written on the very clock where the erase completes gives done=1, good=1 and suspAck=1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Control word write strobe |
| wErs | input | 1 | Erase-select bit of the written word |
| wHv | input | 1 | High-voltage-enable bit of the written word |
| wSusp | input | 1 | Suspend bit of the written word |
| rdReq | input | 1 | Array read request |
| rdAck | output | 1 | Read serviced (registered) |
| rdErr | output | 1 | Read refused, erase active (registered) |
| done | output | 1 | Erase finished |
| good | output | 1 | Erase finished with pass |
| suspAck | output | 1 | Erase held suspended |
| phase | output | PW | Current erase phase |

## Verification
The bench checks the suspend spacing at its exact boundary, MIN_GAP and MIN_GAP+1 edges after a resume. A timer that is off by one would either flag the legal suspend or let the early one pass, and the fail would arrive one suspend too late or too early.

It checks the rollback for phases on and off a checkpoint. A design that resumed from the exact phase, or that rounded upward, would give the wrong phase after resume and a shorter or longer completion time.

It also checks a clear of the suspend bit with high-voltage low, which a careless decoder would accept as a resume. It checks a suspend landing on the completing clock, which a design could drop, leaving suspAck low.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef struct packed {
    logic start;
    logic adv;
    logic resume;
    logic suspReq;
  } seqStrobe_t;
endpackage

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wErs,
  input  logic       wHv,
  input  logic       wSusp,
  input  logic       rdReq,
  input  logic       done,
  output seqStrobe_t stb,
  output logic       suspAck,
  output logic       rdAck,
  output logic       rdErr
);
  logic ers, hv, susp, running;

  assign running = ers & hv & ~susp & ~done;

  always_comb begin
    stb.start   = wrEn & wErs & wHv & ~wSusp & ~hv & ~susp;
    stb.adv     = running;
    stb.resume  = wrEn & ~wSusp & susp & hv;
    stb.suspReq = wrEn & wSusp & ~susp & running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ers <= 1'b0; hv <= 1'b0; susp <= 1'b0;
      rdAck <= 1'b0; rdErr <= 1'b0;
    end else begin
      if (wrEn) begin
        ers <= wErs;
        hv  <= wHv;
        if (wSusp) susp <= 1'b1;
        else if (hv) susp <= 1'b0;
      end
      rdAck <= rdReq & ~running;
      rdErr <= rdReq & running;
    end
  end

  assign suspAck = susp & ers;

  assert_clear_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wSusp && susp && !hv) |=> susp);
  assert_rd_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rdAck && rdErr));
endmodule

// File: rtl/erase_seq_dp.sv
module erase_seq_dp
  import erase_seq_pkg::*;
#(
  parameter int PHASES     = 256,
  parameter int CKPT_BITS  = 3,
  parameter int MIN_GAP    = 20,
  parameter int VIOL_LIMIT = 3,
  localparam int PW = $clog2(PHASES),
  localparam int GW = $clog2(MIN_GAP + 1),
  localparam int VW = $clog2(VIOL_LIMIT + 1)
)(
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    stb,
  output logic [PW-1:0] phase,
  output logic          done,
  output logic          good
);
  localparam logic [PW-1:0] LAST   = PW'(PHASES - 1);
  localparam logic [PW-1:0] CKMASK = ~PW'((1 << CKPT_BITS) - 1);
  localparam logic [GW-1:0] GAPMAX = GW'(MIN_GAP);
  localparam logic [VW-1:0] VLAST  = VW'(VIOL_LIMIT - 1);

  logic [GW-1:0] gap;
  logic [VW-1:0] viol;
  logic          early;

  assign early = stb.suspReq & (gap < GAPMAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0; gap <= '0; viol <= '0;
      done <= 1'b0; good <= 1'b0;
    end else if (stb.start) begin
      phase <= '0; gap <= '0; viol <= '0;
      done <= 1'b0; good <= 1'b0;
    end else begin
      if (stb.adv) begin
        if (phase == LAST) begin
          done <= 1'b1;
          good <= 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
      if (stb.resume) phase <= phase & CKMASK;
      if (stb.resume) gap <= '0;
      else if (gap < GAPMAX) gap <= gap + 1'b1;
      if (early) begin
        viol <= viol + 1'b1;
        if (viol == VLAST) begin
          done <= 1'b1;
          good <= 1'b0;
        end
      end
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.adv && phase != LAST && !stb.start) |=> phase == $past(phase) + 1'b1);
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.adv && !stb.start && !stb.resume) |=> $stable(phase));
  assert_rollback_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.resume |=> (phase[CKPT_BITS-1:0] == '0) && (phase <= $past(phase)));
  assert_fail_count_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && !good) |-> viol == VW'(VIOL_LIMIT));
endmodule

// File: rtl/erase_seq_top.sv
module erase_seq_top
  import erase_seq_pkg::*;
#(
  parameter int PHASES     = 256,
  parameter int CKPT_BITS  = 3,
  parameter int MIN_GAP    = 20,
  parameter int VIOL_LIMIT = 3,
  localparam int PW = $clog2(PHASES)
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          wErs,
  input  logic          wHv,
  input  logic          wSusp,
  input  logic          rdReq,
  output logic          rdAck,
  output logic          rdErr,
  output logic          done,
  output logic          good,
  output logic          suspAck,
  output logic [PW-1:0] phase
);
  seqStrobe_t stb;

  erase_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wErs(wErs), .wHv(wHv),
    .wSusp(wSusp), .rdReq(rdReq), .done(done), .stb(stb),
    .suspAck(suspAck), .rdAck(rdAck), .rdErr(rdErr)
  );

  erase_seq_dp #(
    .PHASES(PHASES), .CKPT_BITS(CKPT_BITS),
    .MIN_GAP(MIN_GAP), .VIOL_LIMIT(VIOL_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .phase(phase), .done(done), .good(good)
  );
endmodule

// File: tb/sim_erase_seq_top.sv
module sim_erase_seq_top;
  localparam int PHASES = 256;
  localparam int CKB    = 3;
  localparam int GAP    = 20;
  localparam int PW     = $clog2(PHASES);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wErs = 1'b0, wHv = 1'b0, wSusp = 1'b0, rdReq = 1'b0;
  logic rdAck, rdErr, done, good, suspAck;
  logic [PW-1:0] phase;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  erase_seq_top #(.PHASES(PHASES), .CKPT_BITS(CKB), .MIN_GAP(GAP), .VIOL_LIMIT(3)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wErs(wErs), .wHv(wHv), .wSusp(wSusp),
    .rdReq(rdReq), .rdAck(rdAck), .rdErr(rdErr), .done(done), .good(good),
    .suspAck(suspAck), .phase(phase)
  );

  function automatic int expRoll(int p);
    return (p / (1 << CKB)) * (1 << CKB);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic e, logic h, logic s);
    wrEn = 1'b1; wErs = e; wHv = h; wSusp = s;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idleWait(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic startOp();
    wr(1'b0, 1'b1, 1'b0);
    wr(1'b0, 1'b0, 1'b0);
    wr(1'b1, 1'b1, 1'b0);
  endtask

  task automatic waitDone(output int cnt);
    cnt = 0;
    while (!done && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic suspendAfter(int n, output int p);
    idleWait(n);
    wr(1'b1, 1'b1, 1'b1);
    p = int'(phase);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt, p, q;
    void'($urandom(32'd12345));
    idleWait(2);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset good", int'(good), 0);
    chk("R3 reset suspAck", int'(suspAck), 0);
    chk("R1 reset phase", int'(phase), 0);
    rstN = 1'b1;
    idleWait(1);

    // R1 / R2: plain erase
    startOp();
    chk("R1 start phase", int'(phase), 0);
    chk("R1 start done", int'(done), 0);
    idleWait(10);
    chk("R2 step phase", int'(phase), 10);
    rdReq = 1'b1; @(negedge clk); rdReq = 1'b0;
    chk("R6 read while running err", int'(rdErr), 1);
    chk("R6 read while running ack", int'(rdAck), 0);
    waitDone(cnt);
    chk("R2 completion time", cnt + 11, PHASES);
    chk("R2 good", int'(good), 1);
    idleWait(3);
    chk("R2 phase holds", int'(phase), PHASES - 1);

    // R3 / R4 / R6: suspend, read, resume
    startOp();
    suspendAfter(29, p);
    chk("R3 phase at suspend", p, 30);
    chk("R3 suspAck", int'(suspAck), 1);
    idleWait(5);
    chk("R3 frozen", int'(phase), 30);
    rdReq = 1'b1; @(negedge clk); rdReq = 1'b0;
    chk("R6 read while suspended ack", int'(rdAck), 1);
    chk("R6 read while suspended err", int'(rdErr), 0);
    chk("R6 read keeps phase", int'(phase), 30);
    wr(1'b1, 1'b1, 1'b0);
    chk("R4 rollback", int'(phase), 24);
    chk("R4 suspAck cleared", int'(suspAck), 0);
    waitDone(cnt);
    chk("R4 longer completion", cnt, PHASES - 24);
    chk("R4 good", int'(good), 1);

    // R5: clear ignored while high-voltage is low
    startOp();
    suspendAfter(40, p);
    wr(1'b1, 1'b0, 1'b1);
    wr(1'b1, 1'b0, 1'b0);
    idleWait(4);
    chk("R5 suspAck kept", int'(suspAck), 1);
    chk("R5 phase frozen", int'(phase), p);
    wr(1'b1, 1'b1, 1'b1);
    chk("R5 no restart", int'(phase), p);
    wr(1'b1, 1'b1, 1'b0);
    chk("R4 rollback after hv restore", int'(phase), expRoll(p));
    waitDone(cnt);
    chk("R5 erase completes", int'(good), 1);

    // R7 / R8: spacing boundary and fail
    startOp();
    suspendAfter(GAP, p);
    chk("R7 first suspend phase", p, GAP + 1);
    wr(1'b1, 1'b1, 1'b0);
    suspendAfter(GAP - 1, p);
    chk("R7 early suspend no fail yet", int'(done), 0);
    wr(1'b1, 1'b1, 1'b0);
    suspendAfter(GAP - 1, p);
    chk("R7 second early suspend no fail yet", int'(done), 0);
    wr(1'b1, 1'b1, 1'b0);
    suspendAfter(GAP, p);
    chk("R7 boundary suspend legal", int'(done), 0);
    chk("R7 boundary phase", p, 69);
    wr(1'b1, 1'b1, 1'b0);
    q = int'(phase);
    suspendAfter(0, p);
    chk("R8 fail done", int'(done), 1);
    chk("R8 fail good", int'(good), 0);
    wr(1'b1, 1'b1, 1'b0);
    idleWait(5);
    chk("R8 erase stopped", int'(phase), expRoll(q + 1));

    // R9: suspend on the completing clock
    startOp();
    while (phase != PW'(PHASES - 1)) @(negedge clk);
    wr(1'b1, 1'b1, 1'b1);
    chk("R9 done", int'(done), 1);
    chk("R9 good", int'(good), 1);
    chk("R9 suspAck", int'(suspAck), 1);

    // random suspend points and reads
    for (int it = 0; it < 8; it++) begin
      int w, hold;
      startOp();
      w = GAP + int'($urandom_range(0, 150));
      suspendAfter(w, p);
      chk("R3 random suspend phase", p, w + 1);
      hold = int'($urandom_range(0, 6));
      for (int k = 0; k < hold; k++) begin
        rdReq = 1'($urandom_range(0, 1));
        q = int'(rdReq);
        @(negedge clk);
        rdReq = 1'b0;
        chk("R6 random read ack", int'(rdAck), q);
      end
      chk("R3 random hold", int'(phase), p);
      wr(1'b1, 1'b1, 1'b0);
      chk("R4 random rollback", int'(phase), expRoll(p));
      waitDone(cnt);
      chk("R2 random completion", cnt, PHASES - expRoll(p));
      chk("R2 random good", int'(good), 1);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule